// File: doc/BRIEF.md
# Pad Attribute Conditioning Stage

This block conditions the signals passing between the pin multiplexer and one pad cell. A small per-pad attribute register holds five control bits. On the output side, those bits shape the core's output value and output enable into the pad drive value, the drive enable and the strong/weak indication. They also supply the pull controls. The analog behaviour of the pad is reduced to digital terms. A resolver combines the core drive, an external drive and the pull setting into a 2-bit resolved level. That level, inverted if so configured, is returned to the core together with a validity flag.

Open-drain output is emulated in logic: whenever the conditioned output would drive a 1, the drive enable is withdrawn, so only a 0 is ever driven. A floating pad is never passed to the core as an unknown; the core receives a defined 0 with the valid flag low. A parameter fixes at elaboration whether the pad is bidirectional or input-only. An input-only pad never drives, whatever the core presents on its output path.

Top module: `pad_cond_stage`

## Requirements
- R1: After reset the attribute register is all zeros: no inversion, no open-drain emulation, no pull, weak drive. An enabled core output therefore reaches the pad unchanged, with `pad_strong_o` low and `pull_en_o` low.
- R2: The attribute bit 0 (invert) complements the core output value on its way to the pad while the output is enabled.
- R3: With attribute bit 1 (open-drain emulation) set, an enabled output whose value after inversion is 1 has `pad_oe_o` cleared; a value of 0 is still driven.
- R4: When the pad is driven neither by the core nor externally, the pull-enable bit (bit 2) sets the level to "pulled" (code 2'b10), with `pull_val_o` equal to the pull-select bit (bit 3). Without a pull, the level is "floating" (code 2'b11).
- R5: `pad_strong_o` equals attribute bit 4 (strong drive) while `pad_oe_o` is 1, and is 0 otherwise.
- R6: When only the external source drives, the level is driven-0 (2'b00) or driven-1 (2'b01) per `ext_val_i`. `core_in_o` is that value, complemented if invert is set.
- R7: When only the core drives, `core_in_o` is the pad's own driven level, complemented if invert is set, and `core_in_valid_o` is 1.
- R8: A floating level gives `core_in_o` = 0 and `core_in_valid_o` = 0. A pulled level gives the pull value, complemented if invert is set, with `core_in_valid_o` = 1.
- R9: When the core and the external source drive at once, `contention_o` is 1 and the level reports the core's driven value.
- R10: With `PadBidir` = 0, `pad_oe_o` and `pad_strong_o` stay 0 whatever the core output path carries. The invert bit still applies to `core_in_o`.
- R11: An attribute write (`attr_we_i` high at a rising edge) takes effect from that edge. With `attr_we_i` low, the attributes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| attr_we_i | input | 1 | Attribute register write enable |
| attr_wdata_i | input | 5 | Attributes: bit0 invert, bit1 open-drain emulation, bit2 pull enable, bit3 pull select, bit4 strong drive |
| core_out_i | input | 1 | Core output value |
| core_oe_i | input | 1 | Core output enable |
| ext_drive_i | input | 1 | External source is driving the pad |
| ext_val_i | input | 1 | Value driven by the external source |
| pad_out_o | output | 1 | Pad drive value (0 when not driving) |
| pad_oe_o | output | 1 | Pad drive enable |
| pad_strong_o | output | 1 | Strong drive while driving |
| pull_en_o | output | 1 | Pull resistor enable |
| pull_val_o | output | 1 | Pull direction |
| pad_level_o | output | 2 | Resolved level: 00 driven-0, 01 driven-1, 10 pulled, 11 floating |
| core_in_o | output | 1 | Conditioned input value to the core |
| core_in_valid_o | output | 1 | Input value is defined (pad not floating) |
| contention_o | output | 1 | Core and external source drive simultaneously |

## Verification
Apart from the attribute register, all paths are combinational. A wrong attribute state therefore shows on the ports in the first cycle after the write edge, as a wrong drive polarity, enable, strength or pull. A fault in the resolver or the input path appears in the same cycle as the stimulus: a wrong level code, a missing contention flag, or a floating pad reported as valid. Each such case is set up from a fixed attribute setting. The ports are then sampled half a cycle later.

// File: rtl/pad_cond_pkg.sv
package pad_cond_pkg;

  // Bit 0 is the least significant field (invert).
  typedef struct packed {
    logic drv_strong;
    logic pull_sel;
    logic pull_en;
    logic od_emul;
    logic invert;
  } pad_attr_t;

  localparam int unsigned AttrW = $bits(pad_attr_t);
  localparam pad_attr_t   AttrReset = '0;

  typedef enum logic [1:0] {
    LvlDrv0  = 2'b00,
    LvlDrv1  = 2'b01,
    LvlPull  = 2'b10,
    LvlFloat = 2'b11
  } pad_lvl_e;

endpackage

// File: rtl/pad_attr_reg.sv
module pad_attr_reg
  import pad_cond_pkg::*;
#(
  parameter pad_attr_t ResetVal = AttrReset
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  pad_attr_t wdata_i,
  output pad_attr_t attr_o
);

  pad_attr_t attr_d, attr_q;

  always_comb begin
    attr_d = attr_q;
    if (we_i) begin
      attr_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_q <= ResetVal;
    end else begin
      attr_q <= attr_d;
    end
  end

  assign attr_o = attr_q;

endmodule

// File: rtl/pad_out_path.sv
module pad_out_path #(
  parameter bit PadBidir = 1'b1
) (
  input  logic core_out_i,
  input  logic core_oe_i,
  input  logic invert_i,
  input  logic od_emul_i,
  input  logic drv_strong_i,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic pad_strong_o
);

  logic oe_gated;
  logic val_cond;
  logic oe_final;

  generate
    if (PadBidir) begin : g_bidir
      assign oe_gated = core_oe_i;
    end else begin : g_inonly
      // Core output path has no influence on an input-only pad.
      assign oe_gated = core_oe_i & 1'b0;
    end
  endgenerate

  always_comb begin
    val_cond = core_out_i ^ invert_i;
    oe_final = oe_gated;
    if (od_emul_i && val_cond) begin
      oe_final = 1'b0;
    end
  end

  assign pad_oe_o     = oe_final;
  assign pad_out_o    = oe_final & val_cond;
  assign pad_strong_o = oe_final & drv_strong_i;

endmodule

// File: rtl/pad_resolve.sv
module pad_resolve
  import pad_cond_pkg::*;
(
  input  logic     pad_oe_i,
  input  logic     pad_out_i,
  input  logic     ext_drive_i,
  input  logic     ext_val_i,
  input  logic     pull_en_i,
  input  logic     pull_sel_i,
  output pad_lvl_e level_o,
  output logic     level_val_o,
  output logic     contention_o
);

  always_comb begin
    contention_o = pad_oe_i & ext_drive_i;
    level_val_o  = 1'b0;
    level_o      = LvlFloat;
    if (pad_oe_i) begin
      level_o     = pad_out_i ? LvlDrv1 : LvlDrv0;
      level_val_o = pad_out_i;
    end else if (ext_drive_i) begin
      level_o     = ext_val_i ? LvlDrv1 : LvlDrv0;
      level_val_o = ext_val_i;
    end else if (pull_en_i) begin
      level_o     = LvlPull;
      level_val_o = pull_sel_i;
    end
  end

endmodule

// File: rtl/pad_in_path.sv
module pad_in_path
  import pad_cond_pkg::*;
(
  input  pad_lvl_e level_i,
  input  logic     level_val_i,
  input  logic     invert_i,
  output logic     core_in_o,
  output logic     core_in_valid_o
);

  always_comb begin
    core_in_valid_o = (level_i != LvlFloat);
    core_in_o       = 1'b0;
    if (core_in_valid_o) begin
      core_in_o = level_val_i ^ invert_i;
    end
  end

endmodule

// File: rtl/pad_cond_stage.sv
module pad_cond_stage
  import pad_cond_pkg::*;
#(
  parameter bit PadBidir = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             attr_we_i,
  input  logic [AttrW-1:0] attr_wdata_i,
  input  logic             core_out_i,
  input  logic             core_oe_i,
  input  logic             ext_drive_i,
  input  logic             ext_val_i,
  output logic             pad_out_o,
  output logic             pad_oe_o,
  output logic             pad_strong_o,
  output logic             pull_en_o,
  output logic             pull_val_o,
  output logic [1:0]       pad_level_o,
  output logic             core_in_o,
  output logic             core_in_valid_o,
  output logic             contention_o
);

  pad_attr_t attr_q;
  pad_lvl_e  level;
  logic      level_val;

  pad_attr_reg #(
    .ResetVal(AttrReset)
  ) u_attr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (attr_we_i),
    .wdata_i(pad_attr_t'(attr_wdata_i)),
    .attr_o (attr_q)
  );

  pad_out_path #(
    .PadBidir(PadBidir)
  ) u_out (
    .core_out_i  (core_out_i),
    .core_oe_i   (core_oe_i),
    .invert_i    (attr_q.invert),
    .od_emul_i   (attr_q.od_emul),
    .drv_strong_i(attr_q.drv_strong),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .pad_strong_o(pad_strong_o)
  );

  pad_resolve u_res (
    .pad_oe_i    (pad_oe_o),
    .pad_out_i   (pad_out_o),
    .ext_drive_i (ext_drive_i),
    .ext_val_i   (ext_val_i),
    .pull_en_i   (attr_q.pull_en),
    .pull_sel_i  (attr_q.pull_sel),
    .level_o     (level),
    .level_val_o (level_val),
    .contention_o(contention_o)
  );

  pad_in_path u_in (
    .level_i        (level),
    .level_val_i    (level_val),
    .invert_i       (attr_q.invert),
    .core_in_o      (core_in_o),
    .core_in_valid_o(core_in_valid_o)
  );

  assign pull_en_o   = attr_q.pull_en;
  assign pull_val_o  = attr_q.pull_sel;
  assign pad_level_o = level;

endmodule

// File: rtl/pad_cond_stage_chk.sv
module pad_cond_stage_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          attr_we_i,
  input logic [AW-1:0] attr_bits,
  input logic          pad_out_o,
  input logic          pad_oe_o,
  input logic          pad_strong_o,
  input logic          pull_en_o,
  input logic [1:0]    pad_level_o,
  input logic          core_in_o,
  input logic          core_in_valid_o,
  input logic          contention_o
);

  assert_od_no_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o && attr_bits[1]) |-> !pad_out_o);

  assert_strong_needs_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_strong_o |-> pad_oe_o);

  assert_pulled_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_level_o == 2'b10) |-> (pull_en_o && !pad_oe_o));

  assert_float_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_level_o == 2'b11) |-> (!core_in_valid_o && !core_in_o));

  assert_contention_core_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    contention_o |-> (pad_oe_o && pad_level_o == {1'b0, pad_out_o}));

  assert_attr_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !attr_we_i |=> $stable(attr_bits));

endmodule

bind pad_cond_stage pad_cond_stage_chk #(.AW(pad_cond_pkg::AttrW)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .attr_we_i      (attr_we_i),
  .attr_bits      (attr_q),
  .pad_out_o      (pad_out_o),
  .pad_oe_o       (pad_oe_o),
  .pad_strong_o   (pad_strong_o),
  .pull_en_o      (pull_en_o),
  .pad_level_o    (pad_level_o),
  .core_in_o      (core_in_o),
  .core_in_valid_o(core_in_valid_o),
  .contention_o   (contention_o)
);

// File: tb/test_pad_cond_stage.sv
module test_pad_cond_stage;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       attr_we_i;
  logic [4:0] attr_wdata_i;
  logic       core_out_i, core_oe_i, ext_drive_i, ext_val_i;

  logic       pad_out_o, pad_oe_o, pad_strong_o, pull_en_o, pull_val_o;
  logic [1:0] pad_level_o;
  logic       core_in_o, core_in_valid_o, contention_o;

  logic       io_out, io_oe, io_strong, io_pen, io_pval;
  logic [1:0] io_level;
  logic       io_in, io_valid, io_cont;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pad_cond_stage #(.PadBidir(1'b1)) i_pad_cond_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .attr_we_i(attr_we_i), .attr_wdata_i(attr_wdata_i),
    .core_out_i(core_out_i), .core_oe_i(core_oe_i), .ext_drive_i(ext_drive_i),
    .ext_val_i(ext_val_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .pad_strong_o(pad_strong_o), .pull_en_o(pull_en_o), .pull_val_o(pull_val_o),
    .pad_level_o(pad_level_o), .core_in_o(core_in_o), .core_in_valid_o(core_in_valid_o),
    .contention_o(contention_o)
  );

  pad_cond_stage #(.PadBidir(1'b0)) i_pad_cond_stage_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .attr_we_i(attr_we_i), .attr_wdata_i(attr_wdata_i),
    .core_out_i(core_out_i), .core_oe_i(core_oe_i), .ext_drive_i(ext_drive_i),
    .ext_val_i(ext_val_i), .pad_out_o(io_out), .pad_oe_o(io_oe),
    .pad_strong_o(io_strong), .pull_en_o(io_pen), .pull_val_o(io_pval),
    .pad_level_o(io_level), .core_in_o(io_in), .core_in_valid_o(io_valid),
    .contention_o(io_cont)
  );

  task automatic chk(input string req, input string what, input logic [1:0] act,
                     input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic write_attr(input logic [4:0] v);
    @(negedge clk_i);
    attr_we_i    = 1'b1;
    attr_wdata_i = v;
    @(negedge clk_i);
    attr_we_i    = 1'b0;
  endtask

  task automatic drive(input logic oe, input logic val, input logic ed, input logic ev);
    core_oe_i   = oe;
    core_out_i  = val;
    ext_drive_i = ed;
    ext_val_i   = ev;
    #1;
  endtask

  task automatic t_reset_R1;
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1", "pad_out", pad_out_o, 1'b1);
    chk("R1", "pad_oe", pad_oe_o, 1'b1);
    chk("R1", "strong", pad_strong_o, 1'b0);
    chk("R1", "pull_en", pull_en_o, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", "float level", pad_level_o, 2'b11);
    chk("R8", "float in", core_in_o, 1'b0);
    chk("R8", "float valid", core_in_valid_o, 1'b0);
  endtask

  task automatic t_invert_R2;
    write_attr(5'b00001);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2", "inverted out", pad_out_o, 1'b0);
    chk("R2", "level", pad_level_o, 2'b00);
    chk("R7", "readback", core_in_o, 1'b1);
    chk("R7", "valid", core_in_valid_o, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2", "inverted out 1", pad_out_o, 1'b1);
    chk("R7", "readback 0", core_in_o, 1'b0);
  endtask

  task automatic t_od_R3;
    write_attr(5'b00010);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R3", "oe dropped on 1", pad_oe_o, 1'b0);
    chk("R3", "level float", pad_level_o, 2'b11);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3", "oe kept on 0", pad_oe_o, 1'b1);
    chk("R3", "drives 0", pad_out_o, 1'b0);
    write_attr(5'b00011);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3", "oe dropped after invert", pad_oe_o, 1'b0);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R3", "inverted 0 driven", pad_oe_o, 1'b1);
  endtask

  task automatic t_pull_R4;
    write_attr(5'b01100);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4", "pulled level", pad_level_o, 2'b10);
    chk("R4", "pull val", pull_val_o, 1'b1);
    chk("R8", "pulled in", core_in_o, 1'b1);
    chk("R8", "pulled valid", core_in_valid_o, 1'b1);
    write_attr(5'b00101);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4", "pull low val", pull_val_o, 1'b0);
    chk("R8", "pulled low inverted", core_in_o, 1'b1);
  endtask

  task automatic t_strong_R5;
    write_attr(5'b10000);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5", "strong driving", pad_strong_o, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5", "no strong idle", pad_strong_o, 1'b0);
  endtask

  task automatic t_ext_R6;
    write_attr(5'b00001);
    drive(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6", "ext level", pad_level_o, 2'b01);
    chk("R6", "ext inverted", core_in_o, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6", "ext inverted 0", core_in_o, 1'b1);
    chk("R9", "no contention", contention_o, 1'b0);
  endtask

  task automatic t_contention_R9;
    write_attr(5'b00000);
    drive(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R9", "contention", contention_o, 1'b1);
    chk("R9", "core value wins", pad_level_o, 2'b00);
  endtask

  task automatic t_inonly_R10;
    write_attr(5'b10001);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R10", "no oe", io_oe, 1'b0);
    chk("R10", "no strong", io_strong, 1'b0);
    chk("R10", "no contention", io_cont, 1'b0);
    chk("R10", "inverted input", io_in, 1'b1);
  endtask

  task automatic t_hold_R11;
    write_attr(5'b00000);
    @(negedge clk_i);
    attr_wdata_i = 5'b00001;
    @(negedge clk_i);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R11", "held without we", pad_out_o, 1'b1);
    attr_we_i = 1'b1;
    #1;
    chk("R11", "not before edge", pad_out_o, 1'b1);
    @(posedge clk_i);
    #1;
    attr_we_i = 1'b0;
    chk("R11", "after edge", pad_out_o, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_ni       = 1'b0;
    attr_we_i    = 1'b0;
    attr_wdata_i = 5'b11111;
    core_out_i   = 1'b0;
    core_oe_i    = 1'b0;
    ext_drive_i  = 1'b0;
    ext_val_i    = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_R1();
    t_invert_R2();
    t_od_R3();
    t_pull_R4();
    t_strong_R5();
    t_ext_R6();
    t_contention_R9();
    t_inonly_R10();
    t_hold_R11();
    finish_run();
  end

endmodule